// File: doc/BRIEF.md
# Two-Bank Pin Controller with Atomic Set and Clear

This block controls 32 general-purpose pins, split into two banks of 16 that have separate addresses. A simple 32-bit register bus (byte address, write strobe, read strobe, write data, registered read data) reaches six per-pin configuration registers in each bank: output level, drive enable, input enable, two alternate-output selects and an alternate-input select. Each bank also has a pad-level read-back register and two transition-flag registers.

Every configuration write is a single word. Its lower half turns features on, and its upper half turns the same pins' features off. Software can therefore change one pin without reading the register first, and concurrent agents cannot lose each other's updates. Pad inputs pass through a two-stage synchronizer. The synchronized levels feed the read-back register and the rising and falling transition detectors, and software clears those flags by writing ones to them. A parameterized reserved-pin mask holds the reserved pins permanently inert.

Top module: `pin_bank_gpio`

## Requirements
- R1: Bit 7 of `bus_addr` selects the bank: 0 is pins 0-15 and 1 is pins 16-31. Within a bank, register word offsets are 0x00 output level, 0x04 drive enable, 0x08 input enable, 0x0C alternate-output A select, 0x10 alternate-output B select, 0x14 alternate-input select, 0x18 pad level, 0x1C rise flags and 0x20 fall flags. Bit n of a bank register belongs to pin 16*bank+n.
- R2: A configuration write with a one in bit n (0..15) sets that feature for pin n of the bank.
- R3: A one in bit n+16 of a configuration write clears that feature for pin n. When bits n and n+16 are both one in the same write, the clear wins.
- R4: Data bits written as zero leave the state of their pins unchanged.
- R5: A read returns the per-pin state of the bank in bits 15:0, and bits 31:16 read as zero.
- R6: `pad_oe` equals the drive-enable state. `pad_out` takes `alt_out_a` when select A is set, otherwise `alt_out_b` when select B is set, and otherwise the output-level state.
- R7: `alt_in_sel` equals the alternate-input select state of all 32 pins.
- R8: The pad-level register reports `pad_in` through two synchronizer flops. A read latched on the first or second clock edge after a pad change still returns the old level, and a read on the third edge returns the new level.
- R9: A rise or fall flag is set when the synchronized level of a pin goes up or down while that pin's input enable is set. Transitions on pins whose input enable is clear latch nothing.
- R10: Writing a one to bit n (0..15) of a flag register clears that flag. Zeros and the upper half of the write have no effect, and a transition detected in the same cycle as the clear wins.
- R11: Pins 23, 29, 30 and 31 are reserved. Writes to them have no effect, their state and level bits read as zero, and they are never driven.
- R12: After synchronous active-low reset, every configuration register and flag is zero, so `pad_oe`, `pad_out` and `alt_in_sel` are zero.
- R13: A read strobe sampled on a clock edge produces `bus_rvalid` high with `bus_rdata` for exactly the following cycle. Without a strobe, `bus_rvalid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte address; bit 7 selects the bank |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data: low half sets, high half clears |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| pad_in | input | 32 | Asynchronous pad input levels |
| alt_out_a | input | 32 | Alternate output source A per pin |
| alt_out_b | input | 32 | Alternate output source B per pin |
| pad_out | output | 32 | Pad output levels |
| pad_oe | output | 32 | Pad drive enables |
| alt_in_sel | output | 32 | Per-pin routing of the pad to an alternate input |

## Verification
The drive-enable register receives four kinds of writes: set-only, a set on a new pin next to pins already set, clear-only, and set and clear of the same pin together. These separate a correct merge from plain overwrite, from ignoring the clear half, and from set-wins precedence. Writes to the upper bank at reserved bit positions, and reads of both banks, separate correct bank decoding from aliasing and show whether the mask is honoured. Pad changes are read back on each of the three edges after the change to pin down the synchronizer depth. Falling and rising transitions on one enabled pin and one disabled pin, followed by flag clears through the upper half and then the lower half, separate correct input-enable gating and write-one-to-clear behaviour from their common faults.

// File: rtl/pbg_pkg.sv
// Shared constants and register selector encoding for the two-bank pin controller.
// Assumes a 32-bit data bus with byte addresses and word-aligned registers.
package pbg_pkg;
    localparam int NUM_BANKS    = 2;
    localparam int ADDR_W       = 8;
    localparam int BANK_SEL_BIT = 7;
    localparam int WORD_LSB     = 2;
    localparam int WORD_W       = 5;
    localparam int NUM_CFG      = 6;

    // Word index within a bank (byte offset = index * 4)
    typedef enum logic [WORD_W-1:0] {
        SEL_OUT_LVL  = 5'd0,
        SEL_DRV_EN   = 5'd1,
        SEL_IN_EN    = 5'd2,
        SEL_ALT_A    = 5'd3,
        SEL_ALT_B    = 5'd4,
        SEL_ALT_IN   = 5'd5,
        SEL_LEVEL    = 5'd6,
        SEL_RISE     = 5'd7,
        SEL_FALL     = 5'd8
    } reg_sel_e;
endpackage

// File: rtl/pbg_sync.sv
// Two-stage synchronizer for asynchronous pad inputs.
// Assumes each bit is independent; no multi-bit coherence is promised.
module pbg_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    // Shift pad levels through two flops
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/pbg_setclr_reg.sv
// One bank-wide feature register with independent set and clear bit vectors.
// Clear beats set; bits outside KEEP are held at zero permanently.
module pbg_setclr_reg #(
    parameter int           W    = 16,
    parameter logic [W-1:0] KEEP = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] set_bits,
    input  logic [W-1:0] clr_bits,
    output logic [W-1:0] q
);
    // Merge set and clear into the stored state on a write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (wr_en) begin
            q <= (q | set_bits) & ~clr_bits & KEEP;
        end
    end
endmodule

// File: rtl/pbg_edge_flags.sv
// Rising and falling transition flags for one bank, cleared by writing ones.
// Assumes 'level' is already synchronous; a new transition outranks a clear.
module pbg_edge_flags #(
    parameter int           W    = 16,
    parameter logic [W-1:0] KEEP = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level,
    input  logic [W-1:0] enable,
    input  logic         rise_clr_en,
    input  logic         fall_clr_en,
    input  logic [W-1:0] clr_bits,
    output logic [W-1:0] rise_q,
    output logic [W-1:0] fall_q
);
    logic [W-1:0] prev;
    logic [W-1:0] rise_ev;
    logic [W-1:0] fall_ev;
    logic [W-1:0] rise_clr;
    logic [W-1:0] fall_clr;

    // Detect enabled transitions and form the clear masks
    always_comb begin
        rise_ev  = level & ~prev & enable & KEEP;
        fall_ev  = ~level & prev & enable & KEEP;
        rise_clr = rise_clr_en ? clr_bits : '0;
        fall_clr = fall_clr_en ? clr_bits : '0;
    end

    // Hold previous level and update the sticky flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev   <= '0;
            rise_q <= '0;
            fall_q <= '0;
        end else begin
            prev   <= level;
            rise_q <= (rise_q & ~rise_clr) | rise_ev;
            fall_q <= (fall_q & ~fall_clr) | fall_ev;
        end
    end
endmodule

// File: rtl/pin_bank_gpio.sv
// Two-bank pin controller: decodes the register bus, holds per-pin feature
// state with atomic set/clear writes, synchronizes pads, latches transitions
// and drives the pad output and drive-enable vectors.
// Assumes bus_wr and bus_rd are not both set in one cycle; if they are,
// the read returns the state before the write.
module pin_bank_gpio
    import pbg_pkg::*;
#(
    parameter int                  BANK_W    = 16,
    parameter logic [2*BANK_W-1:0] RSVD_MASK = 32'hE080_0000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [2*BANK_W-1:0]   bus_wdata,
    output logic [2*BANK_W-1:0]   bus_rdata,
    output logic                  bus_rvalid,
    input  logic [2*BANK_W-1:0]   pad_in,
    input  logic [2*BANK_W-1:0]   alt_out_a,
    input  logic [2*BANK_W-1:0]   alt_out_b,
    output logic [2*BANK_W-1:0]   pad_out,
    output logic [2*BANK_W-1:0]   pad_oe,
    output logic [2*BANK_W-1:0]   alt_in_sel
);
    localparam int DATA_W = 2 * BANK_W;
    localparam int PINS   = NUM_BANKS * BANK_W;

    logic              bank_idx;
    reg_sel_e          word_sel;
    logic [BANK_W-1:0] set_bits;
    logic [BANK_W-1:0] clr_bits;
    logic [PINS-1:0]   level_sync;

    logic [BANK_W-1:0] cfg_q   [NUM_BANKS][NUM_CFG];
    logic [BANK_W-1:0] rise_q  [NUM_BANKS];
    logic [BANK_W-1:0] fall_q  [NUM_BANKS];
    logic [BANK_W-1:0] level_b [NUM_BANKS];
    logic [BANK_W-1:0] rd_slice;

    // Split the address and the write word
    always_comb begin
        bank_idx = bus_addr[BANK_SEL_BIT];
        word_sel = reg_sel_e'(bus_addr[WORD_LSB +: WORD_W]);
        set_bits = bus_wdata[BANK_W-1:0];
        clr_bits = bus_wdata[DATA_W-1:BANK_W];
    end

    pbg_sync #(.W(PINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (level_sync)
    );

    genvar b;
    genvar k;
    generate
        for (b = 0; b < NUM_BANKS; b++) begin : g_bank
            localparam logic [BANK_W-1:0] KEEP = ~RSVD_MASK[b*BANK_W +: BANK_W];
            logic bank_hit;
            assign bank_hit   = bus_wr && (bank_idx == 1'(b));
            assign level_b[b] = level_sync[b*BANK_W +: BANK_W] & KEEP;

            for (k = 0; k < NUM_CFG; k++) begin : g_cfg
                pbg_setclr_reg #(.W(BANK_W), .KEEP(KEEP)) u_reg (
                    .clk      (clk),
                    .rst_n    (rst_n),
                    .wr_en    (bank_hit && (word_sel == reg_sel_e'(k))),
                    .set_bits (set_bits),
                    .clr_bits (clr_bits),
                    .q        (cfg_q[b][k])
                );
            end

            pbg_edge_flags #(.W(BANK_W), .KEEP(KEEP)) u_edges (
                .clk         (clk),
                .rst_n       (rst_n),
                .level       (level_b[b]),
                .enable      (cfg_q[b][SEL_IN_EN]),
                .rise_clr_en (bank_hit && (word_sel == SEL_RISE)),
                .fall_clr_en (bank_hit && (word_sel == SEL_FALL)),
                .clr_bits    (set_bits),
                .rise_q      (rise_q[b]),
                .fall_q      (fall_q[b])
            );

            // Pad output source: alternate A, then alternate B, then level
            for (k = 0; k < BANK_W; k++) begin : g_pin
                localparam int P = b * BANK_W + k;
                always_comb begin
                    if (cfg_q[b][SEL_ALT_A][k]) begin
                        pad_out[P] = alt_out_a[P];
                    end else if (cfg_q[b][SEL_ALT_B][k]) begin
                        pad_out[P] = alt_out_b[P];
                    end else begin
                        pad_out[P] = cfg_q[b][SEL_OUT_LVL][k];
                    end
                end
            end

            assign pad_oe[b*BANK_W +: BANK_W]     = cfg_q[b][SEL_DRV_EN];
            assign alt_in_sel[b*BANK_W +: BANK_W] = cfg_q[b][SEL_ALT_IN];
        end
    endgenerate

    // Select the addressed bank register for a read
    always_comb begin
        rd_slice = '0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (bank_idx == 1'(i)) begin
                case (word_sel)
                    SEL_OUT_LVL: rd_slice = cfg_q[i][SEL_OUT_LVL];
                    SEL_DRV_EN:  rd_slice = cfg_q[i][SEL_DRV_EN];
                    SEL_IN_EN:   rd_slice = cfg_q[i][SEL_IN_EN];
                    SEL_ALT_A:   rd_slice = cfg_q[i][SEL_ALT_A];
                    SEL_ALT_B:   rd_slice = cfg_q[i][SEL_ALT_B];
                    SEL_ALT_IN:  rd_slice = cfg_q[i][SEL_ALT_IN];
                    SEL_LEVEL:   rd_slice = level_b[i];
                    SEL_RISE:    rd_slice = rise_q[i];
                    SEL_FALL:    rd_slice = fall_q[i];
                    default:     rd_slice = '0;
                endcase
            end
        end
    end

    // Register read data and its valid flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= bus_rd;
            if (bus_rd) begin
                bus_rdata <= {{(DATA_W-BANK_W){1'b0}}, rd_slice};
            end
        end
    end
endmodule

// File: rtl/pbg_checker.sv
// Temporal checks on the pin controller's ports, attached by bind.
// Assumes the default register offsets (drive enable at word 1 of bank 0).
module pbg_checker #(
    parameter int                  BANK_W    = 16,
    parameter logic [2*BANK_W-1:0] RSVD_MASK = 32'hE080_0000
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [7:0]            bus_addr,
    input logic                  bus_wr,
    input logic                  bus_rd,
    input logic [2*BANK_W-1:0]   bus_wdata,
    input logic [2*BANK_W-1:0]   bus_rdata,
    input logic                  bus_rvalid,
    input logic [2*BANK_W-1:0]   pad_oe
);
    a_r13_rvalid_after_rd: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid);

    a_r13_no_spurious_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> !bus_rvalid);

    a_r5_upper_half_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> (bus_rdata[2*BANK_W-1:BANK_W] == '0));

    a_r11_reserved_not_driven: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & RSVD_MASK) == '0);

    a_r3_clear_wins_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 8'h04 && bus_wdata[BANK_W]) |=> !pad_oe[0]);

    a_r2_set_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 8'h04 && bus_wdata[0] && !bus_wdata[BANK_W]) |=> pad_oe[0]);
endmodule

bind pin_bank_gpio pbg_checker #(.BANK_W(BANK_W), .RSVD_MASK(RSVD_MASK)) u_pbg_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .pad_oe     (pad_oe)
);

// File: tb/pin_bank_gpio_bench.sv
// Scoreboard bench: read requests push expected words, a monitor pops on rvalid.
module pin_bank_gpio_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [31:0] pad_in = '0;
    logic [31:0] alt_out_a = '0;
    logic [31:0] alt_out_b = '0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;
    logic [31:0] alt_in_sel;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } sb_item_t;
    sb_item_t sb[$];

    always #2.5 clk = ~clk;

    pin_bank_gpio u_pin_bank_gpio (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .pad_in     (pad_in),
        .alt_out_a  (alt_out_a),
        .alt_out_b  (alt_out_b),
        .pad_out    (pad_out),
        .pad_oe     (pad_oe),
        .alt_in_sel (alt_in_sel)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        sb_item_t it;
        it.exp = exp;
        it.tag = tag;
        sb.push_back(it);
        bus_addr = a;
        bus_rd   = 1'b1;
        @(negedge clk);
        bus_rd   = 1'b0;
    endtask

    // Monitor: compare every returned read word with the queued expectation
    always @(negedge clk) begin
        if (bus_rvalid) begin
            if (sb.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R13: actual rvalid with data %08h expected no response", bus_rdata);
            end else begin
                sb_item_t it;
                it = sb.pop_front();
                chk(it.tag, bus_rdata, it.exp);
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: reset state
        chk("R12 pad_oe", pad_oe, 32'h0);
        chk("R12 pad_out", pad_out, 32'h0);
        chk("R12 alt_in_sel", alt_in_sel, 32'h0);
        rd(8'h04, 32'h0, "R12 drive low");
        rd(8'h84, 32'h0, "R12 drive high");
        rd(8'h1C, 32'h0, "R12 rise flags");
        @(negedge clk);
        chk("R13 idle rvalid", {31'b0, bus_rvalid}, 32'h0);

        // R2 / R4 / R3: set, merge, clear, clear-wins
        wr(8'h04, 32'h0000_0005);
        chk("R2 set pins", pad_oe, 32'h0000_0005);
        wr(8'h04, 32'h0000_0002);
        chk("R4 others kept", pad_oe, 32'h0000_0007);
        wr(8'h04, 32'h0004_0000);
        chk("R3 clear pin2", pad_oe, 32'h0000_0003);
        wr(8'h04, 32'h0002_0002);
        chk("R3 clear wins", pad_oe, 32'h0000_0001);

        // R1: upper bank decode
        wr(8'h84, 32'h0000_0001);
        chk("R1 upper bank pin16", pad_oe, 32'h0001_0001);
        rd(8'h84, 32'h0000_0001, "R1 read upper bank");
        rd(8'h04, 32'h0000_0001, "R1 R5 read lower bank");

        // R11: reserved positions in the upper bank
        wr(8'h84, 32'h0000_E080);
        chk("R11 reserved not driven", pad_oe, 32'h0001_0001);
        rd(8'h84, 32'h0000_0001, "R11 reserved read zero");

        // R6: output source priority
        alt_out_a = 32'h0000_0000;
        alt_out_b = 32'hFFFF_FFFF;
        wr(8'h00, 32'h0000_0001);
        chk("R6 level drives", pad_out, 32'h0000_0001);
        wr(8'h0C, 32'h0000_0001);
        chk("R6 alt A selected", pad_out, 32'h0000_0000);
        wr(8'h10, 32'h0000_0001);
        chk("R6 alt A over B", pad_out, 32'h0000_0000);
        wr(8'h0C, 32'h0001_0000);
        chk("R6 alt B selected", pad_out, 32'h0000_0001);
        wr(8'h00, 32'h0001_0000);
        chk("R6 B hides level", pad_out, 32'h0000_0001);
        wr(8'h10, 32'h0001_0000);
        chk("R6 back to level", pad_out, 32'h0000_0000);
        wr(8'h80, 32'h0000_0008);
        chk("R1 upper level pin19", pad_out, 32'h0008_0000);

        // R7: alternate input routing
        wr(8'h94, 32'h0000_0020);
        chk("R7 alt_in_sel pin21", alt_in_sel, 32'h0020_0000);

        // R8: two-flop latency
        pad_in = 32'h0000_00F0;
        rd(8'h18, 32'h0, "R8 edge1 old");
        rd(8'h18, 32'h0, "R8 edge2 old");
        rd(8'h18, 32'h0000_00F0, "R8 edge3 new");

        // R9: no flags while input disabled
        rd(8'h1C, 32'h0, "R9 no rise when disabled");
        rd(8'h20, 32'h0, "R9 no fall when disabled");
        wr(8'h08, 32'h0000_0010);
        pad_in = 32'h0000_00C0;
        repeat (4) @(negedge clk);
        rd(8'h20, 32'h0000_0010, "R9 fall only enabled pin");
        rd(8'h1C, 32'h0, "R9 no rise on fall");
        pad_in = 32'h0000_00D0;
        repeat (4) @(negedge clk);
        rd(8'h1C, 32'h0000_0010, "R9 rise latched");

        // R10: write-one-to-clear
        wr(8'h20, 32'h0010_0000);
        rd(8'h20, 32'h0000_0010, "R10 upper half ignored");
        wr(8'h20, 32'h0000_0010);
        rd(8'h20, 32'h0, "R10 flag cleared");
        rd(8'h1C, 32'h0000_0010, "R10 other flag kept");

        // R11: reserved pad levels and input enable
        pad_in = 32'h2080_00D0;
        repeat (4) @(negedge clk);
        rd(8'h98, 32'h0, "R11 reserved level zero");
        wr(8'h88, 32'h0000_0080);
        rd(8'h88, 32'h0, "R11 reserved enable ignored");

        repeat (3) @(negedge clk);
        chk("R13 all reads answered", 32'(sb.size()), 32'h0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule